// File: doc/BRIEF.md
# Bus quiesce handshake controller

This controller walks a core into and out of its nap or sleep low-power modes using a request/acknowledge exchange with the system. When power-management logic asks for a low-power mode, the controller raises its quiesce request. The system then finishes or pauses any bus traffic that the core would normally snoop. The system answers with an acknowledge. Only after that answer arrives does the controller report that the core is in a low-power state, and only then does it turn snooping off.

A wake event reverses the sequence. Snooping comes back on and the quiesce request is dropped at once. The controller then waits for the system to drop its acknowledge before it returns to normal running. If power management withdraws its request while the controller is still waiting for the acknowledge, the controller abandons the entry and never reports a low-power state. The acknowledge input comes from the system side, so it passes through a configurable synchronizer of `SYNC_STAGES` flops before the state machine uses it.

Top module: `quiesce_ctrl`

## Requirements
- R1: While rst_ni is low, and right after it is released, qreq_o is 0, snoop_en_o is 1, and lp_nap_o and lp_sleep_o are both 0. Reset takes effect asynchronously, including from a low-power state.
- R2: A request on lp_req_i seen in the running state raises qreq_o on the next clock edge, and snoop_en_o stays 1.
- R3: The low-power outputs rise only after qack_i has been seen high through SYNC_STAGES synchronizer flops (default 2) while qreq_o is held. The transition comes on the edge after the synchronized value is high, which is SYNC_STAGES+1 edges after qack_i rises.
- R4: snoop_en_o is 0 exactly while a low-power output is 1, and qreq_o is 1 throughout that time.
- R5: If lp_req_i drops while the controller waits for the acknowledge, qreq_o falls on the next edge and no low-power output is raised. A withdrawal wins over a synchronized acknowledge seen on the same edge.
- R6: In a low-power state only wake_i leaves it. Dropping lp_req_i there has no effect.
- R7: wake_i in a low-power state makes qreq_o 0 and snoop_en_o 1 on the next edge. The controller then ignores lp_req_i until the synchronized qack_i is seen low, and after that it returns to running.
- R8: sleep_sel_i (1 = sleep, 0 = nap) is captured on the edge that accepts the request. Later changes to it are ignored. At most one of lp_nap_o and lp_sleep_o is 1, and that one follows the captured choice.
- R9: wake_i has no effect outside a low-power state, and qack_i has no effect while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lp_req_i | input | 1 | Low-power request from power management |
| sleep_sel_i | input | 1 | Mode choice captured with the request: 1 sleep, 0 nap |
| qack_i | input | 1 | Quiesce acknowledge from the system (asynchronous) |
| wake_i | input | 1 | Wake event |
| qreq_o | output | 1 | Quiesce request to the system |
| snoop_en_o | output | 1 | Enable to the bus snooper |
| lp_nap_o | output | 1 | Core is quiescent in nap mode |
| lp_sleep_o | output | 1 | Core is quiescent in sleep mode |

## Verification
The vector walk first runs one full nap cycle and one full sleep cycle. In each, the acknowledge is held for exactly the synchronizer latency, which separates a correct entry edge from one that is early or late by a cycle. In the sleep cycle the mode select flips after the request is accepted, which shows whether the choice was latched or followed live. Further patterns withdraw the request while waiting, both with and without a synchronized acknowledge present. These tell apart a controller that lets the acknowledge override the withdrawal, or that ignores the withdrawal entirely. Stray wake pulses, a stray acknowledge while running and a withdrawal during low power show whether any path reacts to inputs it should ignore. A directed reset from the sleep state checks the asynchronous return to the idle outputs.

// File: rtl/qc_pkg.sv
package qc_pkg;
  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_REQ_WAIT = 2'd1,
    ST_QUIESCED = 2'd2,
    ST_WAKE     = 2'd3
  } qc_state_e;
endpackage

// File: rtl/qc_sync.sv
module qc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_flops
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else if (STAGES == 1) chain_q <= d_i;
        else chain_q <= {chain_q[STAGES-2:0], d_i};
      end
      assign q_o = chain_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/qc_fsm.sv
module qc_fsm
  import qc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lp_req_i,
  input  logic sleep_sel_i,
  input  logic qack_s_i,
  input  logic wake_i,
  output logic qreq_o,
  output logic snoop_en_o,
  output logic lp_nap_o,
  output logic lp_sleep_o
);
  qc_state_e state_q, state_d;
  logic      sleep_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:      if (lp_req_i) state_d = ST_REQ_WAIT;
      // withdrawal outranks acknowledge
      ST_REQ_WAIT: if (!lp_req_i) state_d = ST_RUN;
                   else if (qack_s_i) state_d = ST_QUIESCED;
      ST_QUIESCED: if (wake_i) state_d = ST_WAKE;
      ST_WAKE:     if (!qack_s_i) state_d = ST_RUN;
      default:     state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      sleep_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RUN && lp_req_i) sleep_q <= sleep_sel_i;
    end
  end

  assign qreq_o     = (state_q == ST_REQ_WAIT) || (state_q == ST_QUIESCED);
  assign snoop_en_o = (state_q != ST_QUIESCED);
  assign lp_nap_o   = (state_q == ST_QUIESCED) && !sleep_q;
  assign lp_sleep_o = (state_q == ST_QUIESCED) && sleep_q;

  // R2
  qreq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(qreq_o) |-> $past(lp_req_i) && snoop_en_o);

  // R3
  lp_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lp_nap_o || lp_sleep_o) |-> $past(qack_s_i) && $past(qreq_o));

  // R4
  snoop_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(snoop_en_o) |-> qreq_o && $past(qreq_o));

  // R5
  withdraw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_REQ_WAIT && !lp_req_i) |=> !qreq_o && !lp_nap_o && !lp_sleep_o);

  // R7
  wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((lp_nap_o || lp_sleep_o) && wake_i) |=> !qreq_o && snoop_en_o);

  // R8
  mode_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lp_nap_o, lp_sleep_o}));

  // R8
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_sleep_o && $past(lp_nap_o || lp_sleep_o)) |-> $past(lp_sleep_o));
endmodule

// File: rtl/quiesce_ctrl.sv
module quiesce_ctrl #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lp_req_i,
  input  logic sleep_sel_i,
  input  logic qack_i,
  input  logic wake_i,
  output logic qreq_o,
  output logic snoop_en_o,
  output logic lp_nap_o,
  output logic lp_sleep_o
);
  logic qack_s;

  qc_sync #(.STAGES(SYNC_STAGES)) u_qack_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (qack_i),
    .q_o    (qack_s)
  );

  qc_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lp_req_i    (lp_req_i),
    .sleep_sel_i (sleep_sel_i),
    .qack_s_i    (qack_s),
    .wake_i      (wake_i),
    .qreq_o      (qreq_o),
    .snoop_en_o  (snoop_en_o),
    .lp_nap_o    (lp_nap_o),
    .lp_sleep_o  (lp_sleep_o)
  );
endmodule

// File: tb/quiesce_ctrl_tb.sv
module quiesce_ctrl_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 38;

  // {lp_req, sleep_sel, qack, wake, exp_qreq, exp_snoop, exp_nap, exp_sleep}
  localparam logic [7:0] VEC [NVEC] = '{
    8'b0000_0100, 8'b1000_1100, 8'b1000_1100, 8'b1010_1100, 8'b1010_1100,
    8'b1010_1010, 8'b0010_1010, 8'b0011_0100, 8'b0000_0100, 8'b0000_0100,
    8'b0000_0100, 8'b1100_1100, 8'b1010_1100, 8'b1010_1100, 8'b1010_1001,
    8'b1010_1001, 8'b1011_0100, 8'b1000_0100, 8'b0000_0100, 8'b0000_0100,
    8'b1000_1100, 8'b1000_1100, 8'b0000_0100, 8'b0000_0100, 8'b1010_1100,
    8'b1010_1100, 8'b0010_0100, 8'b0000_0100, 8'b0000_0100, 8'b0001_0100,
    8'b1001_1100, 8'b1001_1100, 8'b0000_0100, 8'b0010_0100, 8'b0010_0100,
    8'b0010_0100, 8'b0000_0100, 8'b0000_0100
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lp_req = 1'b0, sleep_sel = 1'b0, qack = 1'b0, wake = 1'b0;
  logic qreq, snoop_en, lp_nap, lp_sleep;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quiesce_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .lp_req_i(lp_req), .sleep_sel_i(sleep_sel),
    .qack_i(qack), .wake_i(wake), .qreq_o(qreq), .snoop_en_o(snoop_en),
    .lp_nap_o(lp_nap), .lp_sleep_o(lp_sleep)
  );

  function automatic string vec_tag(int i);
    if (i <= 1)  return "R2";
    if (i <= 5)  return "R3";
    if (i == 6)  return "R6";
    if (i <= 10) return "R7";
    if (i <= 16) return "R8";
    if (i <= 19) return "R7";
    if (i <= 28) return "R5";
    return "R9";
  endfunction

  task automatic check(string tag, logic [3:0] exp);
    logic [3:0] act;
    act = {qreq, snoop_en, lp_nap, lp_sleep};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {qreq,snoop,nap,sleep} actual %b expected %b", tag, act, exp);
    end
    // R4: snoop off iff low power, with qreq held
    n_chk++;
    if ((!snoop_en) !== (lp_nap || lp_sleep) || (!snoop_en && !qreq)) begin
      n_fail++;
      $display("FAIL R4: snoop=%b qreq=%b nap=%b sleep=%b actual mismatch expected snoop==!lp", snoop_en, qreq, lp_nap, lp_sleep);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD/4);
    check("R1", 4'b0100);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", 4'b0100);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      {lp_req, sleep_sel, qack, wake} = VEC[i][7:4];
      @(posedge clk); #1;
      check(vec_tag(i), VEC[i][3:0]);
    end

    // R1: async reset out of sleep
    @(negedge clk);
    {lp_req, sleep_sel, qack, wake} = 4'b1100;
    @(negedge clk) sleep_sel = 1'b0; qack = 1'b1;
    repeat (3) @(negedge clk);
    #1 check("R8", 4'b1001);
    #(CLK_PERIOD/4) rst_n = 1'b0;
    #1 check("R1", 4'b0100);
    lp_req = 1'b0; qack = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1 check("R1", 4'b0100);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule